// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer with a 32-bit register port. A free-running counter advances on each pulse of a slow timebase strobe (nominally 31250 Hz). It runs when the always-run enable is set, or when the awake-only enable is set and the core reports that it is awake. The counter is shifted right by a 4-bit scale, and the low 16 bits of the result form the scaled count. The scaled count is compared with a 16-bit compare value. When it reaches that value, the block latches a pending flag, which also drives the interrupt output. The block can also clear the counter, and can raise a single-cycle reset request.

Every register write except a write to the key register has to be armed first by writing a fixed key word. One key arms exactly one write. Software services the watchdog by writing a fixed magic word to the feed register, which restarts the count. Reads are combinational from a separate read address and need no key.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, all readable registers read zero and both `irq_o` and `wdt_rst_o` are low.
- R2: Writing 0x0051F15E to offset 0x1C arms exactly one following write. A write to any other offset while the block is unarmed is discarded. Any write consumes the arming, and a key write with a different value leaves the block unarmed.
- R3: An armed write of 0x0D09F00D to offset 0x18 clears the counter. An armed feed write with any other value leaves the count unchanged.
- R4: The counter at offset 0x08 increments by one per `tick_i` pulse while config bit 12 is set, or while config bit 13 is set and `core_awake_i` is high.
- R5: With config bits 12 and 13 both clear, ticks leave the count unchanged.
- R6: Offset 0x10 reads the counter shifted right by config[3:0], truncated to 16 bits.
- R7: The compare register at offset 0x20 keeps only write bits [15:0]; bits [31:16] read zero.
- R8: While an enable is set and the scaled count is at least the compare value, config bit 28 and `irq_o` become set on the next cycle. They stay set until an armed config write with bit 28 at zero clears them.
- R9: With config bit 9 set, the counter reads zero once a match has occurred.
- R10: With config bit 8 set, the start of a match produces exactly one one-cycle `wdt_rst_o` pulse. With bit 8 clear, no pulse is produced.
- R11: Config bits [3:0], 8, 9, 12 and 13 read back as written at offset 0x00. The other bits read zero, apart from bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| core_awake_i | input | 1 | High while the core is awake |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Pending flag |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
A write or tick sampled at one rising edge changes register and counter state straight after that edge. Reads are combinational, so their values can be taken on the following falling edge. A match is combinational from the counter; the pending flag, the interrupt and the reset pulse follow one edge later, and a counter clear on match lands on that same later edge. For these reasons the bench drives inputs on falling edges and reads back at least one full cycle after the stimulus. It counts reset pulses on every falling edge across the whole window, so both a missing pulse and a repeated pulse are caught.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SCALED = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FEED   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CMP    = 8'h20;

  localparam logic [DATA_W-1:0] KEY_WORD  = 32'h0051_F15E;
  localparam logic [DATA_W-1:0] FEED_WORD = 32'h0D09_F00D;

  // config bit positions, decoded by software
  localparam int unsigned B_RST_EN  = 8;
  localparam int unsigned B_ZERO    = 9;
  localparam int unsigned B_ALWAYS  = 12;
  localparam int unsigned B_AWAKE   = 13;
  localparam int unsigned B_PEND    = 28;

  typedef struct packed {
    logic       pend;
    logic       run_awake;
    logic       run_always;
    logic       zero_on_hit;
    logic       rst_en;
    logic [3:0] scale;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hit_i,
  output wdt_cfg_t          cfg_o,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              feed_ok_o
);
  logic             armed_q, armed_d;
  wdt_cfg_t         cfg_q, cfg_d;
  logic [CMP_W-1:0] cmp_q, cmp_d;
  logic             key_wr, acc_wr, acc_cfg;

  always_comb begin
    key_wr  = wr_en_i && (wr_addr_i == OFF_KEY);
    acc_wr  = wr_en_i && !key_wr && armed_q;
    acc_cfg = acc_wr && (wr_addr_i == OFF_CFG);

    if (key_wr)       armed_d = (wr_data_i == KEY_WORD);
    else if (wr_en_i) armed_d = 1'b0;
    else              armed_d = armed_q;

    cfg_d = cfg_q;
    if (acc_cfg) begin
      cfg_d.scale       = wr_data_i[3:0];
      cfg_d.rst_en      = wr_data_i[B_RST_EN];
      cfg_d.zero_on_hit = wr_data_i[B_ZERO];
      cfg_d.run_always  = wr_data_i[B_ALWAYS];
      cfg_d.run_awake   = wr_data_i[B_AWAKE];
      cfg_d.pend        = cfg_q.pend & wr_data_i[B_PEND];
    end else begin
      cfg_d.pend        = cfg_q.pend | hit_i;
    end

    cmp_d = cmp_q;
    if (acc_wr && (wr_addr_i == OFF_CMP)) cmp_d = wr_data_i[CMP_W-1:0];

    feed_ok_o = acc_wr && (wr_addr_i == OFF_FEED) && (wr_data_i == FEED_WORD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cfg_q   <= '0;
      cmp_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cfg_q   <= cfg_d;
      cmp_q   <= cmp_d;
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;

  AST_UNARMED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !armed_q && wr_addr_i == OFF_CMP) |=> $stable(cmp_q)); // R2
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.pend && !(wr_en_i && wr_addr_i == OFF_CFG)) |=> cfg_q.pend); // R8
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned SCL_W = 4,
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             core_awake_i,
  input  logic             run_always_i,
  input  logic             run_awake_i,
  input  logic             zero_on_hit_i,
  input  logic [SCL_W-1:0] scale_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             feed_ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMP_W-1:0] scaled_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, shifted;
  logic             enabled, count_en;

  always_comb begin
    enabled  = run_always_i || run_awake_i;
    count_en = tick_i && (run_always_i || (run_awake_i && core_awake_i));
    shifted  = cnt_q >> scale_i;
    scaled_o = shifted[CMP_W-1:0];
    hit_o    = enabled && (scaled_o >= cmp_i);

    if (feed_ok_i)                  cnt_d = '0;
    else if (hit_o && zero_on_hit_i) cnt_d = '0;
    else if (count_en)              cnt_d = cnt_q + 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_FEED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_ok_i |=> (cnt_q == '0)); // R3
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_always_i && !run_awake_i && !feed_ok_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic rst_en_i,
  output logic pulse_o
);
  logic hit_q, pulse_q, pulse_d;

  always_comb pulse_d = hit_i && !hit_q && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      hit_q   <= hit_i;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R10
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned CMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              core_awake_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam int unsigned SCL_W = 4;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  wdt_cfg_t         cfg;
  logic [CMP_W-1:0] cmp, scaled;
  logic [CNT_W-1:0] cnt;
  logic             hit, feed_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wdt_regs #(.CMP_W(CMP_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .hit_i(hit), .cfg_o(cfg), .cmp_o(cmp),
    .feed_ok_o(feed_ok)
  );

  wdt_counter #(.CNT_W(CNT_W), .SCL_W(SCL_W), .CMP_W(CMP_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i), .core_awake_i(core_awake_i),
    .run_always_i(cfg.run_always), .run_awake_i(cfg.run_awake),
    .zero_on_hit_i(cfg.zero_on_hit), .scale_i(cfg.scale), .cmp_i(cmp),
    .feed_ok_i(feed_ok), .cnt_o(cnt), .scaled_o(scaled), .hit_o(hit)
  );

  wdt_pulse u_pulse (
    .clk_i(clk_i), .rst_ni(rst_n), .hit_i(hit), .rst_en_i(cfg.rst_en),
    .pulse_o(wdt_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFF_CFG: begin
        rd_data_o[3:0]      = cfg.scale;
        rd_data_o[B_RST_EN] = cfg.rst_en;
        rd_data_o[B_ZERO]   = cfg.zero_on_hit;
        rd_data_o[B_ALWAYS] = cfg.run_always;
        rd_data_o[B_AWAKE]  = cfg.run_awake;
        rd_data_o[B_PEND]   = cfg.pend;
      end
      OFF_COUNT:  rd_data_o = DATA_W'(cnt);
      OFF_SCALED: rd_data_o = DATA_W'(scaled);
      OFF_CMP:    rd_data_o = DATA_W'(cmp);
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o = cfg.pend;

  AST_IRQ_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hit && !(wr_en_i && wr_addr_i == OFF_CFG)) |=> irq_o); // R8
  AST_NO_PULSE_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg.rst_en |=> !wdt_rst_o); // R10
endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        awake = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, wrst;

  int n_chk = 0;
  int n_fail = 0;
  int n_pulse = 0;

  localparam logic [7:0]  A_CFG = 8'h00, A_CNT = 8'h08, A_SCL = 8'h10,
                          A_FEED = 8'h18, A_KEY = 8'h1C, A_CMP = 8'h20;
  localparam logic [31:0] KEYW = 32'h0051_F15E, FEEDW = 32'h0D09_F00D;

  always #2 clk = ~clk;

  wdt_keyed u_wdt_keyed (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .core_awake_i(awake),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .wdt_rst_o(wrst)
  );

  always @(negedge clk) if (wrst) n_pulse++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kwr(input logic [7:0] a, input logic [31:0] d);
    wr(A_KEY, KEYW);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // {armed, waddr, wdata, raddr, expected}
  localparam int NV = 6;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'h20, 32'h0000_1234, 8'h20, 32'h0000_1234}, // R7 plain compare
    {1'b1, 8'h20, 32'hABCD_5678, 8'h20, 32'h0000_5678}, // R7 upper bits dropped
    {1'b0, 8'h20, 32'h0000_1111, 8'h20, 32'h0000_5678}, // R2 unarmed write lost
    {1'b1, 8'h00, 32'hF0F0_030F, 8'h00, 32'h0000_030F}, // R11 config fields
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_030F}, // R2 unarmed config lost
    {1'b1, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000}  // R11 config cleared
  };

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CFG, v); check("R1 cfg", v, 0);
    rd(A_CNT, v); check("R1 count", v, 0);
    rd(A_CMP, v); check("R1 cmp", v, 0);
    check("R1 irq/rst", {30'd0, irq, wrst}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) kwr(VEC[i][79:72], VEC[i][71:40]);
      else            wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      check($sformatf("R%0d vec%0d", (i < 2) ? 7 : ((i == 2 || i == 4) ? 2 : 11), i), v, VEC[i][31:0]);
    end

    // R2 one key arms one write only; wrong key does not arm
    wr(A_KEY, KEYW); wr(A_CMP, 32'h22); wr(A_CMP, 32'h33);
    rd(A_CMP, v); check("R2 single arm", v, 32'h22);
    wr(A_KEY, 32'h1234); wr(A_CMP, 32'h44);
    rd(A_CMP, v); check("R2 wrong key", v, 32'h22);

    // R4 always-run counting
    kwr(A_CMP, 32'hFFFF);
    kwr(A_CFG, 32'h0000_1000);
    ticks(10);
    rd(A_CNT, v); check("R4 always run", v, 10);
    // R3 bad feed ignored, good feed clears
    kwr(A_FEED, 32'h0D09_F00E);
    rd(A_CNT, v); check("R3 bad feed", v, 10);
    kwr(A_FEED, FEEDW);
    rd(A_CNT, v); check("R3 good feed", v, 0);
    // R4 awake-only mode
    kwr(A_CFG, 32'h0000_2000);
    ticks(4);
    rd(A_CNT, v); check("R4 asleep", v, 0);
    awake = 1'b1; ticks(4);
    rd(A_CNT, v); check("R4 awake", v, 4);
    // R5 both enables clear
    kwr(A_CFG, 32'h0);
    ticks(4);
    rd(A_CNT, v); check("R5 hold", v, 4);
    // R6 scale
    kwr(A_FEED, FEEDW);
    kwr(A_CFG, 32'h0000_1003);
    ticks(20);
    rd(A_SCL, v); check("R6 scale3", v, 2);
    kwr(A_CFG, 32'h0000_000F);
    rd(A_SCL, v); check("R6 scale15", v, 0);

    // R8 R10 match with reset enable, no zeroing
    kwr(A_CFG, 32'h0);
    kwr(A_FEED, FEEDW);
    kwr(A_CMP, 32'h3);
    p0 = n_pulse;
    kwr(A_CFG, 32'h0000_1100);
    check("R8 no early irq", {31'd0, irq}, 0);
    ticks(3);
    repeat (6) @(negedge clk);
    check("R10 one pulse", n_pulse - p0, 1);
    check("R8 irq", {31'd0, irq}, 1);
    rd(A_CFG, v); check("R8 pend bit", v, 32'h1000_1100);
    wr(A_CFG, 32'h0);
    check("R8 unarmed clear ignored", {31'd0, irq}, 1);
    kwr(A_CFG, 32'h0);
    rd(A_CFG, v); check("R8 cleared", v, 0);

    // R9 zero on match, R10 no pulse without enable
    kwr(A_FEED, FEEDW);
    p0 = n_pulse;
    kwr(A_CFG, 32'h0000_1200);
    ticks(3);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R9 zeroed", v, 0);
    check("R9 irq", {31'd0, irq}, 1);
    check("R10 no pulse", n_pulse - p0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule